// File: doc/BRIEF.md
# TAP Configuration Loader

This block loads a configuration bitstream into a single programmable device through its IEEE 1149.1 test access port. After a start pulse it drives TCK, TMS and TDI through a fixed walk of the TAP state machine. It first resets the TAP and loads a configuration-load instruction. Then it shifts the whole bitstream through the data register, loads a startup instruction, clocks the device's startup sequence in Run-Test/Idle and parks the TAP in Test-Logic-Reset.

The bitstream arrives as 32-bit words over a valid/ready handshake. The total bit count is given with the start pulse, and the TCK rate is set by an integer divider from the system clock. The divider has a floor that keeps TCK at or below its maximum rate. TDO is not used. When the word stream runs dry in the middle of the data shift, the block holds TCK low until the next word arrives, so no filler data ever reaches the device.

Top module: `tap_cfg_loader`

## Requirements
- R1: After reset, and while no load is running, tck=0, tms=1, tdi=0, busy=0, done=0 and word_ready=0.
- R2: After an accepted start, the first ten TCK rising edges carry TMS 1,1,1,1,1 then 0 then 1,1 then 0,0, all with TDI=0.
- R3: The next six rising edges shift the configuration-load code 6'b000101 LSB first on TDI, with TMS=0 on the first five and TMS=1 on the sixth. When bit_count is non-zero, four edges with TMS 1,1,0,0 and TDI=0 follow.
- R4: The data shift sends exactly bit_count bits. Words are taken in order and each word is sent from bit 31 downward. TMS=0 on every data bit except the last, which has TMS=1. Exactly ceil(bit_count/32) words are accepted, and the unused low bits of the final word are never sent.
- R5: After the data shift, the edges carry TMS 1, 0, then 1,1, then 0,0. Next comes the startup code 6'b001100, LSB first, with the same TMS scheme as R3. Then TMS=1 once, 16 edges with TMS=0, and 3 edges with TMS=1. TDI=0 on every edge outside the two codes and the data. Then busy=0 and done=1.
- R6: While a data bit is due and no word is held, TCK stays low and no rising edge occurs.
- R7: TMS and TDI never change while TCK is high.
- R8: Each TCK high phase, and each low phase that is not a pause, lasts max(tck_div, HALF_MIN) system clock cycles, with HALF_MIN=2 by default. tck_div=0 therefore gives a TCK period of 4 cycles.
- R9: A start pulse while busy=1 is ignored: the running sequence, and its bit count, are unaffected.
- R10: A start with bit_count=0 sets err_empty=1. It skips the data shift: after the configuration code the edges carry TMS 1 then 0, continuing with the 1,1,0,0 of R5, for 48 edges in total. No word is accepted.
- R11: done and err_empty hold their values until the next accepted start, which clears done and sets busy in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin a load |
| bit_count | input | CNT_W | Total bitstream length in bits, sampled at start |
| tck_div | input | DIV_W | TCK half-period in system clocks (floored at HALF_MIN) |
| word_data | input | 32 | Bitstream word, first bit in bit 31 |
| word_valid | input | 1 | word_data holds a word |
| word_ready | output | 1 | Block can take a word this cycle |
| tck | output | 1 | Test clock to target |
| tms | output | 1 | Test mode select to target |
| tdi | output | 1 | Test data to target |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load completed |
| err_empty | output | 1 | Last load was started with a zero bit count |

## Verification
The full TMS/TDI stream at every rising TCK edge is compared with a model in five patterns. A 40-bit stream whose last word has junk low bits shows the partial-word cut and the word count. A 32-bit stream whose word arrives late separates a true pause from a clock that keeps running. A zero count shows the shortened path and the error flag. A short run hit by a second start shows that start is ignored while busy. Divider values 0, 2 and 3 separate the clamp from the programmed ratio.

// File: rtl/tapcfg_pkg.sv
// Shared definitions for the TAP configuration loader: the step list of the
// fixed TAP walk, the instruction codes and small decode helpers.
// Assumes the step order below is the order in which steps are executed.
package tapcfg_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI0, ST_SELIR0, ST_SHIR0, ST_CFGOP, ST_TODR, ST_SHDR,
        ST_DATA, ST_UPDR, ST_RTI1, ST_SELIR1, ST_SHIR1, ST_STOP, ST_UPIR,
        ST_STARTUP, ST_EXIT
    } step_e;

    localparam logic [5:0] OP_CFG_LOAD = 6'b000101;
    localparam logic [5:0] OP_STARTUP  = 6'b001100;

    // TMS value driven on every bit of a step except a merged last bit
    function automatic logic step_tms(step_e s);
        case (s)
            ST_TLR, ST_SELIR0, ST_TODR, ST_UPDR,
            ST_SELIR1, ST_UPIR, ST_EXIT:        return 1'b1;
            default:                            return 1'b0;
        endcase
    endfunction

    // Number of TCK cycles of a fixed-length step (data/startup set elsewhere)
    function automatic logic [4:0] step_len(step_e s);
        case (s)
            ST_TLR:               return 5'd5;
            ST_CFGOP, ST_STOP:    return 5'd6;
            ST_EXIT:              return 5'd3;
            ST_SELIR0, ST_SHIR0, ST_TODR, ST_SHDR,
            ST_SELIR1, ST_SHIR1:  return 5'd2;
            default:              return 5'd1;
        endcase
    endfunction

    // Shift steps whose last bit is merged with TMS=1
    function automatic logic step_merge_last(step_e s);
        return (s == ST_CFGOP) || (s == ST_DATA) || (s == ST_STOP);
    endfunction

    // Select one bit of an instruction code
    function automatic logic op_bit(logic [5:0] op, logic [2:0] idx);
        logic [5:0] sh;
        sh = op >> idx;
        return sh[0];
    endfunction

endpackage

// File: rtl/tck_pacer.sv
// TCK generator. Produces a TCK with half-period max(div, HALF_MIN) system
// clocks. A rising edge is only produced while 'run' is high; the low phase
// is stretched otherwise. 'adv' marks the cycle on whose edge TCK falls.
// Assumes run is only evaluated while TCK is low.
module tck_pacer #(
    parameter int DIV_W    = 8,
    parameter int HALF_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tck,
    output logic             adv
);
    localparam logic [DIV_W-1:0] HALF_FLOOR = DIV_W'(HALF_MIN);

    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] pc;
    logic             phase_end;
    logic             tck_seen;
    logic [7:0]       lvl;

    // Clamp the programmed half-period to the rate floor
    always_comb begin
        half      = (div < HALF_FLOOR) ? HALF_FLOOR : div;
        phase_end = (pc == half - DIV_W'(1));
        adv       = tck && phase_end;
    end

    // Count each phase and toggle TCK at its end; hold low when not running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck <= 1'b0;
            pc  <= '0;
        end else if (tck) begin
            if (phase_end) begin
                tck <= 1'b0;
                pc  <= '0;
            end else begin
                pc <= pc + DIV_W'(1);
            end
        end else if (run) begin
            if (phase_end) begin
                tck <= 1'b1;
                pc  <= '0;
            end else begin
                pc <= pc + DIV_W'(1);
            end
        end else begin
            pc <= '0;
        end
    end

    // Measure how long TCK has held its level (checking aid)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck_seen <= 1'b0;
            lvl      <= '0;
        end else begin
            tck_seen <= tck;
            if (tck != tck_seen) lvl <= '0;
            else if (lvl != 8'hFF) lvl <= lvl + 8'd1;
        end
    end

    AST_TCK_LEVEL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tck != tck_seen) |-> (int'(lvl) >= HALF_MIN - 1)) // R8
        else $error("TCK level shorter than floor");

endmodule

// File: rtl/bit_feeder.sv
// Bitstream word buffer. Takes 32-bit words over valid/ready while words of
// the current load remain, and presents the next bit (MSB first). A shift
// consumes one bit; the word is released after bit 0 or after the last bit
// of the stream, so unused low bits are dropped.
// Assumes 'load' is a single-cycle pulse at the start of a load.
module bit_feeder #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] bit_count,
    input  logic             shift,
    input  logic             flush,
    input  logic [31:0]      word_data,
    input  logic             word_valid,
    output logic             word_ready,
    output logic             have_bit,
    output logic             cur_bit
);
    logic [31:0]      wbuf;
    logic             wvld;
    logic [4:0]       pos;
    logic [CNT_W-1:0] left;

    // Drive handshake and current bit from the buffer state
    always_comb begin
        word_ready = !wvld && (left != '0);
        have_bit   = wvld;
        cur_bit    = wbuf[31];
    end

    // Load the word budget, accept words and shift bits out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbuf <= '0;
            wvld <= 1'b0;
            pos  <= '0;
            left <= '0;
        end else if (load) begin
            wvld <= 1'b0;
            pos  <= '0;
            left <= (bit_count >> 5) + CNT_W'(|bit_count[4:0]);
        end else if (word_ready && word_valid) begin
            wbuf <= word_data;
            wvld <= 1'b1;
            left <= left - CNT_W'(1);
        end else if (shift) begin
            wbuf <= wbuf << 1;
            pos  <= pos + 5'd1;
            if (flush || pos == 5'd31) begin
                wvld <= 1'b0;
                pos  <= '0;
            end
        end
    end

    AST_SHIFT_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> wvld) // R4
        else $error("bit consumed without a word");

endmodule

// File: rtl/tap_seq_ctrl.sv
// Step sequencer for the fixed TAP walk. Tracks the current step and the
// bit index inside it, advances on each TCK falling edge ('adv'), and
// derives TMS/TDI for the bit now presented. A zero bit count jumps from the
// configuration code straight to the Update/Run-Test path.
// Assumes 'adv' only pulses while a TCK high phase ends.
module tap_seq_ctrl
    import tapcfg_pkg::*;
#(
    parameter int CNT_W        = 24,
    parameter int STARTUP_TCKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] bit_count,
    input  logic             adv,
    input  logic             have_bit,
    input  logic             data_bit,
    output logic             tms,
    output logic             tdi,
    output logic             busy,
    output logic             done,
    output logic             err_empty,
    output logic             run,
    output logic             load,
    output logic             data_shift,
    output logic             data_last
);
    localparam int STARTUP_N = (STARTUP_TCKS < 16) ? 16 : STARTUP_TCKS;

    step_e            step;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nbits_q;
    logic [CNT_W-1:0] len_c;
    logic             last_c;

    // Length of the current step and last-bit detect
    always_comb begin
        case (step)
            ST_DATA:    len_c = nbits_q;
            ST_STARTUP: len_c = CNT_W'(STARTUP_N);
            default:    len_c = CNT_W'(step_len(step));
        endcase
        last_c = (cnt == len_c - CNT_W'(1));
    end

    // Pin values for the bit currently presented to the target
    always_comb begin
        if (!busy)                                  tms = 1'b1;
        else if (last_c && step_merge_last(step))   tms = 1'b1;
        else                                        tms = step_tms(step);
        case (step)
            ST_CFGOP: tdi = busy && op_bit(OP_CFG_LOAD, cnt[2:0]);
            ST_STOP:  tdi = busy && op_bit(OP_STARTUP, cnt[2:0]);
            ST_DATA:  tdi = busy && data_bit;
            default:  tdi = 1'b0;
        endcase
        load       = start && !busy;
        run        = busy && !(step == ST_DATA && !have_bit);
        data_shift = busy && adv && (step == ST_DATA);
        data_last  = last_c;
    end

    // Start a load, then walk steps on each TCK falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step      <= ST_TLR;
            cnt       <= '0;
            nbits_q   <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            err_empty <= 1'b0;
        end else if (load) begin
            step      <= ST_TLR;
            cnt       <= '0;
            nbits_q   <= bit_count;
            busy      <= 1'b1;
            done      <= 1'b0;
            err_empty <= (bit_count == '0);
        end else if (busy && adv) begin
            if (last_c) begin
                cnt <= '0;
                case (step)
                    ST_CFGOP: step <= (nbits_q == '0) ? ST_UPDR : ST_TODR;
                    ST_EXIT: begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                    default:  step <= step_e'(step + 4'd1);
                endcase
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(nbits_q)) // R9
        else $error("start accepted while busy");

    AST_ERR_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err_empty |-> (nbits_q == '0)) // R10
        else $error("error flag with non-zero count");

endmodule

// File: rtl/tap_cfg_loader.sv
// Top of the TAP configuration loader. Connects the TCK pacer, the bitstream
// word buffer and the step sequencer. TMS/TDI move only when TCK falls or,
// during a data pause, while TCK is held low.
// Assumes a single target device on the TAP and TDO left unused.
module tap_cfg_loader #(
    parameter int CNT_W        = 24,
    parameter int DIV_W        = 8,
    parameter int HALF_MIN     = 2,
    parameter int STARTUP_TCKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] bit_count,
    input  logic [DIV_W-1:0] tck_div,
    input  logic [31:0]      word_data,
    input  logic             word_valid,
    output logic             word_ready,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic             busy,
    output logic             done,
    output logic             err_empty
);
    logic run, adv, load, data_shift, data_last, have_bit, cur_bit;

    tck_pacer #(.DIV_W(DIV_W), .HALF_MIN(HALF_MIN)) u_pacer (
        .clk(clk), .rst_n(rst_n), .run(run), .div(tck_div),
        .tck(tck), .adv(adv)
    );

    bit_feeder #(.CNT_W(CNT_W)) u_feeder (
        .clk(clk), .rst_n(rst_n), .load(load), .bit_count(bit_count),
        .shift(data_shift), .flush(data_last),
        .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
        .have_bit(have_bit), .cur_bit(cur_bit)
    );

    tap_seq_ctrl #(.CNT_W(CNT_W), .STARTUP_TCKS(STARTUP_TCKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_count(bit_count),
        .adv(adv), .have_bit(have_bit), .data_bit(cur_bit),
        .tms(tms), .tdi(tdi), .busy(busy), .done(done), .err_empty(err_empty),
        .run(run), .load(load), .data_shift(data_shift), .data_last(data_last)
    );

    AST_PINS_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi))) // R7
        else $error("TMS/TDI moved while TCK high");

    AST_STARVED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tck && !run) |=> !tck) // R6
        else $error("TCK rose without data");

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)) // R11
        else $error("busy and done together");

endmodule

// File: tb/tap_cfg_loader_bench.sv
// Directed bench: each task runs one load scenario and checks the TMS/TDI
// stream seen at every TCK rising edge against a model built from the
// requirements, plus flags, word counts and TCK timing.
module tap_cfg_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 24;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] bit_count = '0;
    logic [DIV_W-1:0] tck_div = 8'd2;
    logic [31:0] word_data = '0;
    logic word_valid = 1'b0;
    logic word_ready, tck, tms, tdi, busy, done, err_empty;

    tap_cfg_loader u_tap_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_count(bit_count),
        .tck_div(tck_div), .word_data(word_data), .word_valid(word_valid),
        .word_ready(word_ready), .tck(tck), .tms(tms), .tdi(tdi),
        .busy(busy), .done(done), .err_empty(err_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Rising-edge log of the TAP pins, sampled away from clk edges
    logic log_tms [0:255];
    logic log_tdi [0:255];
    int   rise_cyc [0:255];
    int   nrise = 0;
    int   hi_glitch = 0;
    logic tck_prev = 1'b0;
    logic tms_h = 1'b1;
    logic tdi_h = 1'b0;
    always @(negedge clk) begin
        if (tck && !tck_prev) begin
            if (nrise < 256) begin
                log_tms[nrise]  = tms;
                log_tdi[nrise]  = tdi;
                rise_cyc[nrise] = cyc;
            end
            nrise++;
        end
        if (tck && tck_prev && (tms !== tms_h || tdi !== tdi_h)) hi_glitch++;
        tms_h = tms;
        tdi_h = tdi;
        tck_prev = tck;
    end

    // Word source with optional stall
    logic [31:0] src [0:3];
    int   src_n = 0;
    int   src_idx = 0;
    int   taken = 0;
    int   stall_until = 0;
    logic pend = 1'b0;
    always @(negedge clk) begin
        if (pend) begin
            src_idx++;
            taken++;
        end
        word_valid = (src_idx < src_n) && (cyc >= stall_until);
        word_data  = (src_idx < 4) ? src[src_idx] : 32'h0;
        pend = word_valid && word_ready;
    end

    // Expected stream model
    logic exp_tms [0:255];
    logic exp_tdi [0:255];
    int   exp_n = 0;

    task automatic put(input logic m, input logic d);
        exp_tms[exp_n] = m;
        exp_tdi[exp_n] = d;
        exp_n++;
    endtask

    task automatic put_run(input logic m, input int k);
        for (int i = 0; i < k; i++) put(m, 1'b0);
    endtask

    task automatic put_op(input logic [5:0] op);
        for (int i = 0; i < 6; i++) put(i == 5, op[i]);
    endtask

    task automatic build_exp(input int n);
        exp_n = 0;
        put_run(1, 5); put_run(0, 1); put_run(1, 2); put_run(0, 2);
        put_op(6'b000101);
        if (n > 0) begin
            put_run(1, 2); put_run(0, 2);
            for (int i = 0; i < n; i++) put(i == n - 1, src[i / 32][31 - (i % 32)]);
        end
        put_run(1, 1); put_run(0, 1); put_run(1, 2); put_run(0, 2);
        put_op(6'b001100);
        put_run(1, 1); put_run(0, 16); put_run(1, 3);
    endtask

    task automatic chk(input string tag, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic cmp_range(input int lo, input int hi, input string tag);
        int bad = -1;
        for (int i = lo; i < hi; i++)
            if (bad < 0 && (log_tms[i] !== exp_tms[i] || log_tdi[i] !== exp_tdi[i])) bad = i;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s: rise %0d actual tms,tdi=%b%b expected %b%b",
                     tag, bad, log_tms[bad], log_tdi[bad], exp_tms[bad], exp_tdi[bad]);
        end
    endtask

    // Set up a load and pulse start; checks busy/done right after acceptance
    task automatic kick(input int n, input int div, input int nwords, input int stall);
        @(posedge clk); #1;
        nrise = 0; hi_glitch = 0; src_idx = 0; taken = 0; pend = 1'b0;
        src_n = nwords; stall_until = cyc + stall;
        bit_count = CNT_W'(n); tck_div = DIV_W'(div);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk("R11 start sets busy and clears done", busy === 1'b1 && done === 1'b0,
            {busy, done}, 2);
    endtask

    task automatic wait_done();
        int t = 0;
        while (done !== 1'b1 && t < 20000) begin
            @(posedge clk); t++;
        end
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic check_stream(input int n);
        build_exp(n);
        chk("R5 rising edge count", nrise == exp_n, nrise, exp_n);
        cmp_range(0, 10, "R2 reset and IR path");
        if (n > 0) begin
            cmp_range(10, 20, "R3 config code and DR path");
            cmp_range(20, 20 + n, "R4 data bits");
            cmp_range(20 + n, exp_n, "R5 closing sequence");
        end else begin
            cmp_range(10, 16, "R3 config code");
            cmp_range(16, exp_n, "R10 shortened closing sequence");
        end
        chk("R5 done set busy clear", done === 1'b1 && busy === 1'b0, {busy, done}, 1);
        chk("R7 pins stable while TCK high", hi_glitch == 0, hi_glitch, 0);
    endtask

    task automatic t_reset();
        chk("R1 idle pins", tck === 1'b0 && tms === 1'b1 && tdi === 1'b0,
            {tck, tms, tdi}, 3'b010);
        chk("R1 idle flags", busy === 1'b0 && done === 1'b0 && word_ready === 1'b0,
            {busy, done, word_ready}, 0);
    endtask

    task automatic t_basic();
        src[0] = 32'hA5C3_0F1E;
        src[1] = 32'h9000_00FF;
        kick(40, 2, 2, 0);
        wait_done();
        check_stream(40);
        chk("R4 words accepted", taken == 2, taken, 2);
        chk("R4 no word requested after load", word_ready === 1'b0, word_ready, 0);
        chk("R10 no error on non-zero count", err_empty === 1'b0, err_empty, 0);
        chk("R8 period at div 2", rise_cyc[1] - rise_cyc[0] == 4,
            rise_cyc[1] - rise_cyc[0], 4);
    endtask

    task automatic t_stall();
        src[0] = 32'h8000_0001;
        kick(32, 3, 1, 300);
        repeat (200) @(posedge clk);
        #1;
        chk("R6 TCK held low while starved", tck === 1'b0, tck, 0);
        chk("R6 no edge past the pre-data bits", nrise == 20, nrise, 20);
        chk("R6 word requested while starved", word_ready === 1'b1, word_ready, 1);
        wait_done();
        check_stream(32);
        chk("R8 period at div 3", rise_cyc[1] - rise_cyc[0] == 6,
            rise_cyc[1] - rise_cyc[0], 6);
        chk("R11 done holds", done === 1'b1, done, 1);
    endtask

    task automatic t_zero();
        src[0] = 32'hFFFF_FFFF;
        kick(0, 0, 1, 0);
        wait_done();
        check_stream(0);
        chk("R10 error flag set", err_empty === 1'b1, err_empty, 1);
        chk("R10 no word accepted", taken == 0, taken, 0);
        chk("R8 floor at div 0", rise_cyc[1] - rise_cyc[0] == 4,
            rise_cyc[1] - rise_cyc[0], 4);
        repeat (10) @(posedge clk);
        #1;
        chk("R11 error flag holds", err_empty === 1'b1, err_empty, 1);
    endtask

    task automatic t_busy_start();
        src[0] = 32'hB4FF_FFFF;
        kick(8, 2, 1, 0);
        chk("R11 start clears error flag", err_empty === 1'b0, err_empty, 0);
        repeat (30) @(posedge clk);
        #1;
        bit_count = '0;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done();
        check_stream(8);
        chk("R9 second start ignored, no error", err_empty === 1'b0, err_empty, 0);
        chk("R9 single word accepted", taken == 1, taken, 1);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_basic();
        t_stall();
        t_zero();
        t_busy_start();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule